// File: doc/BRIEF.md
# Saturating Event Statistics with Maskable Interrupt

This block collects event statistics for one direction of a MAC path. Eight unsigned counters track good frames, bytes, dropped frames, dropped bytes, CRC errors, pause frames, multicast frames and broadcast frames. The datapath pulses one strobe per counter for each event. The two byte counters add an amount carried alongside the strobes. Every other counter adds one.

A counter never wraps. Once it would pass its maximum, it stays at the maximum and latches a sticky overflow bit in a status register. A separate status bit records that a good frame completed. Software works through a small register port. It clears status bits by writing ones, masks them, forces them through a mirror address, and reads the counters. Reading a counter also clears that counter's overflow bit. One level-sensitive interrupt output is the OR of the status bits that are not masked.

A single path enable gates all new activity. While the enable is low, the counters hold their values and no status bit can be newly set. Bits that are already latched are kept.

Top module: `mac_stat_irq`

## Requirements
- R1: After reset, every counter, the status register and the mask register are zero, and `irq` is low.
- R2: While `path_en` is 1, a strobe on `evt_strobe[i]` adds one to counter i. Counters 1 (bytes) and 3 (dropped bytes) are the exception: they add `evt_bytes`. Counter order is 0 frames, 1 bytes, 2 dropped frames, 3 dropped bytes, 4 CRC errors, 5 pause, 6 multicast, 7 broadcast. Several strobes may be active in the same cycle.
- R3: If an addition would exceed the all-ones maximum, the counter holds the maximum and status bit i+1 is set. An addition that lands exactly on the maximum sets no status bit.
- R4: While `path_en` is 0, strobes leave all counters unchanged. Writes to the mirror address set nothing. Status bits that are already set are kept.
- R5: A write to address 0 clears each status bit whose data bit is 1. Data bits that are 0 have no effect.
- R6: If hardware sets a status bit in the same cycle that software clears it, by a write to address 0 or by a counter read, the bit ends up set.
- R7: While enabled, a write to address 2 sets each status bit whose data bit is 1. A read of address 2 returns the status register.
- R8: `irq` is high exactly when some status bit is 1 and its mask bit is 0. The mask register is at address 1.
- R9: A read presents its data on `reg_rdata` in the cycle after `reg_rd`, and `reg_rdata` holds until the next read. Addresses 8+i return counter i. A read of counter i clears status bit i+1.
- R10: Status bit 0 is set whenever `evt_strobe[0]` is seen while enabled, including when the frame counter is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_en | input | 1 | Path enable; 0 freezes counters and blocks new status |
| evt_strobe | input | NUM_CNT | One event pulse per counter |
| evt_bytes | input | AMT_W | Increment for the byte counters |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | NUM_CNT+1 | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The assertions check four things on every cycle: no counter ever decreases, counters and new status stay frozen while the path is disabled, every hardware set lands in the status register, and a fully masked register keeps `irq` low. The bench's scenarios are the only way to show the rest. That covers the exact saturation point (landing on the maximum versus passing it), the race between a set and a clear in the same cycle, overflow clearing on a counter read, the mirror readback, and data-dependent byte increments. A behavioural model compares `irq` and `reg_rdata` on every cycle throughout these scenarios.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int ADDR_W   = 4;
  localparam int N_CNT    = 8;
  // counter order; status bit i+1 belongs to counter i
  localparam int C_FRM    = 0;
  localparam int C_BYT    = 1;
  localparam int C_DFRM   = 2;
  localparam int C_DBYT   = 3;
  localparam int C_CRC    = 4;
  localparam int C_PAU    = 5;
  localparam int C_MCAST  = 6;
  localparam int C_BCAST  = 7;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;
  localparam logic [ADDR_W-1:0] A_FORCE  = 4'h2;
  localparam int                A_CNT0   = 8;

  function automatic bit takes_amount(int idx);
    return (idx == C_BYT) || (idx == C_DBYT);
  endfunction
endpackage

// File: rtl/mstat_counter.sv
module mstat_counter #(
  parameter int CNT_W = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [AMT_W-1:0] amount,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int PAD = CNT_W + 1 - AMT_W;

  logic [CNT_W:0] sum;
  assign sum = {1'b0, count} + {{PAD{1'b0}}, amount};
  assign ovf = advance & sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (advance) count <= sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/mstat_status.sv
module mstat_status #(
  parameter int STAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [STAT_W-1:0] hw_set,
  input  logic [STAT_W-1:0] sw_clr,
  input  logic [STAT_W-1:0] sw_force,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STAT_W-1:0] force_q;
  assign force_q = en ? sw_force : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      // sets are applied after clears so they win a same-cycle race
      status <= (status & ~sw_clr) | hw_set | force_q;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/mstat_regif.sv
module mstat_regif
  import mac_stat_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int STAT_W  = NUM_CNT + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [STAT_W-1:0]        reg_wdata,
  input  logic [STAT_W-1:0]        status,
  input  logic [STAT_W-1:0]        mask,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic                     mask_we,
  output logic [STAT_W-1:0]        w1c,
  output logic [STAT_W-1:0]        force_set,
  output logic [STAT_W-1:0]        rd_clr,
  output logic [DATA_W-1:0]        reg_rdata
);
  assign mask_we   = reg_wr && (reg_addr == A_MASK);
  assign w1c       = (reg_wr && (reg_addr == A_STATUS)) ? reg_wdata : '0;
  assign force_set = (reg_wr && (reg_addr == A_FORCE))  ? reg_wdata : '0;

  assign rd_clr[0] = 1'b0;
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_rdclr
    assign rd_clr[g+1] = reg_rd && (reg_addr == ADDR_W'(A_CNT0 + g));
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_STATUS || reg_addr == A_FORCE) rd_mux = DATA_W'(status);
    else if (reg_addr == A_MASK)                     rd_mux = DATA_W'(mask);
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr == ADDR_W'(A_CNT0 + i))
        rd_mux = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq
  import mac_stat_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int AMT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_CNT = N_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               path_en,
  input  logic [NUM_CNT-1:0] evt_strobe,
  input  logic [AMT_W-1:0]   evt_bytes,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_CNT:0]   reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  localparam int STAT_W = NUM_CNT + 1;

  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       ovf_vec;
  logic [STAT_W-1:0]        set_vec, status_q, mask_q, w1c, force_set, rd_clr;
  logic                     mask_we;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [AMT_W-1:0] amt;
    if (takes_amount(g)) begin : g_amt
      assign amt = evt_bytes;
    end else begin : g_one
      assign amt = AMT_W'(1);
    end
    mstat_counter #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (path_en & evt_strobe[g]),
      .amount  (amt),
      .count   (cnt_flat[g*CNT_W +: CNT_W]),
      .ovf     (ovf_vec[g])
    );
  end

  assign set_vec = {ovf_vec, path_en & evt_strobe[C_FRM]};

  mstat_status #(.STAT_W(STAT_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (path_en),
    .hw_set     (set_vec),
    .sw_clr     (w1c | rd_clr),
    .sw_force   (force_set),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .status     (status_q),
    .mask       (mask_q),
    .irq        (irq)
  );

  mstat_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status    (status_q),
    .mask      (mask_q),
    .cnt_flat  (cnt_flat),
    .mask_we   (mask_we),
    .w1c       (w1c),
    .force_set (force_set),
    .rd_clr    (rd_clr),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/mac_stat_irq_chk.sv
module mac_stat_irq_chk #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int STAT_W  = NUM_CNT + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     path_en,
  input logic                     irq,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [STAT_W-1:0]        status_q,
  input logic [STAT_W-1:0]        mask_q,
  input logic [STAT_W-1:0]        set_vec
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_mono
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W]));
  end

  a_r4_frozen_counts: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |=> $stable(cnt_flat));

  a_r4_no_new_status: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |=> ((status_q & ~$past(status_q)) == '0));

  a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  a_r8_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);
endmodule

bind mac_stat_irq mac_stat_irq_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .path_en  (path_en),
  .irq      (irq),
  .cnt_flat (cnt_flat),
  .status_q (status_q),
  .mask_q   (mask_q),
  .set_vec  (set_vec)
);

// File: tb/test_mac_stat_irq.sv
module test_mac_stat_irq;
  localparam int CW = 8;
  localparam int AW = 8;
  localparam int NC = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, path_en = 0, reg_wr = 0, reg_rd = 0;
  logic [NC-1:0] evt_strobe = '0;
  logic [AW-1:0] evt_bytes = '0;
  logic [3:0]    reg_addr = '0;
  logic [NC:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 0;

  mac_stat_irq #(.CNT_W(CW), .AMT_W(AW), .DATA_W(32), .NUM_CNT(NC)) i_mac_stat_irq (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .evt_strobe(evt_strobe),
    .evt_bytes(evt_bytes), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #4 clk = ~clk;

  // behavioural reference model
  int   m_cnt[NC];
  logic [NC:0] m_stat, m_mask;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_stat = '0; m_mask = '0; m_rdata = '0;
    end else begin
      logic [NC:0] set, clr;
      set = '0; clr = '0;
      if (reg_rd) begin
        if (reg_addr == 0 || reg_addr == 2) m_rdata = 32'(m_stat);
        else if (reg_addr == 1)             m_rdata = 32'(m_mask);
        else if (reg_addr >= 8)             m_rdata = 32'(m_cnt[reg_addr-8]);
        else                                m_rdata = '0;
        if (reg_addr >= 8) clr[reg_addr-7] = 1'b1;
      end
      if (reg_wr && reg_addr == 0) clr = clr | reg_wdata;
      if (reg_wr && reg_addr == 1) m_mask = reg_wdata;
      if (path_en && reg_wr && reg_addr == 2) set = set | reg_wdata;
      if (path_en) begin
        if (evt_strobe[0]) set[0] = 1'b1;
        for (int i = 0; i < NC; i++) if (evt_strobe[i]) begin
          int amt;
          amt = (i == 1 || i == 3) ? int'(evt_bytes) : 1;
          if (m_cnt[i] + amt > CMAX) begin m_cnt[i] = CMAX; set[i+1] = 1'b1; end
          else m_cnt[i] = m_cnt[i] + amt;
        end
      end
      m_stat = (m_stat & ~clr) | set;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (irq !== (|(m_stat & ~m_mask))) begin
      bad++; $display("FAIL R8 model irq act=%0d exp=%0d", irq, |(m_stat & ~m_mask));
    end
    total++;
    if (reg_rdata !== m_rdata) begin
      bad++; $display("FAIL R9 model rdata act=%0h exp=%0h", reg_rdata, m_rdata);
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic strobe(logic [NC-1:0] s, int amt);
    evt_strobe = s; evt_bytes = AW'(amt);
    @(negedge clk); evt_strobe = '0; evt_bytes = '0;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = (NC+1)'(d);
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(int a, output int v);
    reg_rd = 1; reg_addr = 4'(a);
    @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v);  check("R1 status after reset", v, 0);
    rd(8, v);  check("R1 frame count after reset", v, 0);
    rd(1, v);  check("R1 mask after reset", v, 0);
    check("R1 irq after reset", int'(irq), 0);

    path_en = 1;
    repeat (3) strobe(8'h01, 0);
    rd(8, v);  check("R2 frame count", v, 3);
    rd(0, v);  check("R10 frame done bit", v, 'h001);
    check("R8 irq unmasked", int'(irq), 1);
    strobe(8'h02, 100); strobe(8'h02, 100);
    rd(9, v);  check("R2 byte count by amount", v, 200);
    strobe(8'h08, 7);
    rd(11, v); check("R2 dropped byte amount", v, 7);
    strobe(8'hF4, 5);
    rd(15, v); check("R2 parallel strobes bcast", v, 1);
    rd(11, v); check("R2 dropped byte untouched", v, 7);
    strobe(8'h02, 100);
    rd(0, v);  check("R3 byte overflow bit", v, 'h005);
    rd(9, v);  check("R3 byte count saturated", v, CMAX);
    rd(0, v);  check("R9 read clears overflow", v, 'h001);

    wr(1, 'h1FF);
    check("R8 all masked", int'(irq), 0);
    wr(1, 'h1FE);
    check("R8 bit0 unmasked", int'(irq), 1);
    wr(0, 'h001);
    rd(0, v);  check("R5 w1c clears", v, 0);
    check("R8 irq after clear", int'(irq), 0);
    wr(1, 0);

    wr(2, 'h100);
    path_en = 0;
    strobe(8'hFF, 50);
    rd(8, v);  check("R4 frame frozen", v, 3);
    rd(9, v);  check("R4 byte frozen", v, CMAX);
    wr(2, 'h0FF);
    rd(0, v);  check("R4 status kept, force blocked", v, 'h100);
    wr(0, 'h100);

    path_en = 1;
    wr(2, 'h010);
    rd(2, v);  check("R7 mirror readback", v, 'h010);
    rd(0, v);  check("R7 status shows forced bit", v, 'h010);

    strobe(8'h01, 0);
    evt_strobe = 8'h01; reg_wr = 1; reg_addr = 0; reg_wdata = 'h001;
    @(negedge clk); evt_strobe = '0; reg_wr = 0; reg_wdata = '0;
    rd(0, v);  check("R6 set beats w1c", v, 'h011);
    rd(8, v);  check("R2 frame count after race", v, 5);
    wr(0, 0);
    rd(0, v);  check("R5 zero write ignored", v, 'h011);

    evt_strobe = 8'h02; evt_bytes = 1; reg_rd = 1; reg_addr = 9;
    @(negedge clk); evt_strobe = '0; evt_bytes = '0; reg_rd = 0;
    check("R9 read data of saturated count", int'(reg_rdata), CMAX);
    rd(0, v);  check("R6 set beats read clear", v, 'h015);

    for (int k = 0; k < CMAX - 1; k++) strobe(8'h20, 0);
    rd(13, v); check("R3 pause at max", v, CMAX);
    rd(0, v);  check("R3 exact max no overflow", v, 'h015);
    strobe(8'h20, 0);
    rd(0, v);  check("R3 pause overflow bit", v, 'h055);
    rd(13, v); check("R3 pause held at max", v, CMAX);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule